// File: doc/BRIEF.md
# Eight-Pin I/O Port with Change Interrupt

This block is a register-controlled general-purpose I/O port. A host reaches eleven 8-bit registers through a simple port with an address, write data and strobes. Through them it sets each pin as an input or an output, drives the output levels and optionally inverts what it reads from input pins. Each pad is split into an input level, an output level and an output enable, so the pad ring builds the actual three-state buffer.

The interrupt unit watches every enabled pin after a two-stage synchronizer. Each pin chooses one of two rules. It can fire when the pin differs from its value on the previous clock, or when the pin differs from a per-pin default bit. The first qualifying event sets a pending state, records one pin in the flag register and takes a snapshot of the port in the capture register. All three then stay frozen until the host reads the capture or port register. The interrupt pin can be push-pull with either polarity, or open-drain, where only the enable is driven.

Top module: `gpio_ioc_port`

## Requirements
- R1: After a synchronous reset the direction register reads 0xFF and every pad enable is 0. The output latch, flag, capture and all other registers are 0, and the interrupt pin is inactive: irq_out=1 and irq_oe=1.
- R2: Registers sit at these addresses: direction 0x00, input inversion 0x01, interrupt enable 0x02, default compare 0x03, compare select 0x04, configuration 0x05, pull-up store 0x06, flag 0x07, capture 0x08, port 0x09, output latch 0x0A. A read strobe loads rd_data on that clock edge, and rd_data holds until the next read.
- R3: pin_oe equals the inverse of the direction register, where 1 means input. pin_out equals the output latch. A write to either 0x09 or 0x0A loads the output latch.
- R4: A read of 0x09 returns the pin level after two synchronizer flops, XORed with the inversion bit on input pins only. A pin change therefore first shows in a port read two clocks later.
- R5: A pin with its enable bit set and its compare-select bit 0 raises an interrupt when its synchronized level differs from its level one clock earlier.
- R6: A pin with its compare-select bit set raises an interrupt while its level differs from its default bit. If the mismatch persists after a clearing read, the interrupt is raised again.
- R7: While an interrupt is pending, the flag register holds exactly one set bit. When several pins qualify together, that bit is the lowest-numbered pin.
- R8: When an interrupt is raised, the capture register takes the port read value of that clock. It keeps that value after later pin changes and after the interrupt is cleared.
- R9: A read of 0x08 or 0x09 clears the pending interrupt and the flag. Reads of other addresses leave the interrupt pending.
- R10: While an interrupt is pending, no new event changes the flag or the capture register.
- R11: Configuration bit 1 set makes the interrupt active high, and clear makes it active low, in push-pull mode with irq_oe=1. Configuration bit 2 set selects open-drain mode: irq_out=0 and irq_oe equals the pending state.
- R12: Addresses above 0x0A read as 0 and ignore writes. Writes to 0x07 and 0x08 change nothing.
- R13: A pin whose interrupt-enable bit is 0 never raises an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | W | Registered read data |
| pin_in | input | W | Pad input levels (asynchronous) |
| pin_out | output | W | Pad output levels |
| pin_oe | output | W | Pad output enables |
| irq_out | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin drive enable |

## Verification
Most internal faults reach the ports quickly. A wrong flag or capture value shows up on the next host read of 0x07 or 0x08. A stuck pending state shows on irq_out or irq_oe on the clock after the fault. A stale previous-value reference shows as an extra or missing interrupt within the two synchronizer clocks that follow a pin edge. The reference model in the bench predicts every output on every clock, so an early or late pending transition is caught at the exact cycle it happens rather than at the next read.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
  // register offsets (host visible map)
  localparam int unsigned REG_DIR  = 0;
  localparam int unsigned REG_INV  = 1;
  localparam int unsigned REG_IEN  = 2;
  localparam int unsigned REG_DEFV = 3;
  localparam int unsigned REG_CSEL = 4;
  localparam int unsigned REG_CFG  = 5;
  localparam int unsigned REG_PULL = 6;
  localparam int unsigned REG_FLAG = 7;
  localparam int unsigned REG_CAP  = 8;
  localparam int unsigned REG_PORT = 9;
  localparam int unsigned REG_OLAT = 10;
  // configuration bit positions
  localparam int unsigned CFG_ACT_HIGH   = 1;
  localparam int unsigned CFG_OPEN_DRAIN = 2;
endpackage

// File: rtl/gpio_ioc_sync.sv
module gpio_ioc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) st_q[k] <= '0;
    end else begin
      st_q[0] <= din;
      for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
    end
  end

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/gpio_ioc_detect.sv
module gpio_ioc_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] view,
  input  logic [W-1:0] ien,
  input  logic [W-1:0] csel,
  input  logic [W-1:0] defv,
  input  logic         clr,
  output logic         pend,
  output logic [W-1:0] flag,
  output logic [W-1:0] cap
);
  logic [W-1:0] prev_q, hit, pick, flag_q, cap_q;
  logic         pend_q;

  // per-pin qualifying event
  always_comb hit = ien & ((csel & (pins ^ defv)) | (~csel & (pins ^ prev_q)));

  // lowest-numbered qualifying pin wins
  always_comb begin
    pick = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (hit[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= 1'b0;
      flag_q <= '0;
      cap_q  <= '0;
    end else begin
      if (!pend_q || clr) prev_q <= pins;
      if (pend_q && clr) begin
        pend_q <= 1'b0;
        flag_q <= '0;
      end else if (!pend_q && (|hit)) begin
        pend_q <= 1'b1;
        flag_q <= pick;
        cap_q  <= view;
      end
    end
  end

  assign pend = pend_q;
  assign flag = flag_q;
  assign cap  = cap_q;
endmodule

// File: rtl/gpio_ioc_irqpad.sv
module gpio_ioc_irqpad (
  input  logic pend,
  input  logic act_high,
  input  logic open_drain,
  output logic irq_out,
  output logic irq_oe
);
  always_comb begin
    if (open_drain) begin
      irq_out = 1'b0;
      irq_oe  = pend;
    end else begin
      irq_out = act_high ? pend : ~pend;
      irq_oe  = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port
  import gpio_ioc_pkg::*;
#(
  parameter int W           = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  output logic [W-1:0]      rd_data,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic              irq_out,
  output logic              irq_oe
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(REG_DIR);
  localparam logic [ADDR_W-1:0] A_INV  = ADDR_W'(REG_INV);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(REG_IEN);
  localparam logic [ADDR_W-1:0] A_DEFV = ADDR_W'(REG_DEFV);
  localparam logic [ADDR_W-1:0] A_CSEL = ADDR_W'(REG_CSEL);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(REG_CFG);
  localparam logic [ADDR_W-1:0] A_PULL = ADDR_W'(REG_PULL);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(REG_FLAG);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(REG_CAP);
  localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(REG_PORT);
  localparam logic [ADDR_W-1:0] A_OLAT = ADDR_W'(REG_OLAT);

  logic [W-1:0] dir_q, inv_q, ien_q, defv_q, csel_q, cfg_q, pull_q, olat_q;
  logic [W-1:0] pins_s, port_view, rd_mux, flag_q, cap_q;
  logic         pend_q, clr_rd;

  gpio_ioc_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(pins_s)
  );

  assign port_view = pins_s ^ (inv_q & dir_q);
  assign clr_rd    = rd_en && ((addr == A_CAP) || (addr == A_PORT));

  gpio_ioc_detect #(.W(W)) u_det (
    .clk(clk), .rst(rst), .pins(pins_s), .view(port_view),
    .ien(ien_q), .csel(csel_q), .defv(defv_q), .clr(clr_rd),
    .pend(pend_q), .flag(flag_q), .cap(cap_q)
  );

  gpio_ioc_irqpad u_irq (
    .pend(pend_q), .act_high(cfg_q[CFG_ACT_HIGH]),
    .open_drain(cfg_q[CFG_OPEN_DRAIN]),
    .irq_out(irq_out), .irq_oe(irq_oe)
  );

  // control register bank
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      inv_q  <= '0;
      ien_q  <= '0;
      defv_q <= '0;
      csel_q <= '0;
      cfg_q  <= '0;
      pull_q <= '0;
      olat_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DIR:          dir_q  <= wr_data;
        A_INV:          inv_q  <= wr_data;
        A_IEN:          ien_q  <= wr_data;
        A_DEFV:         defv_q <= wr_data;
        A_CSEL:         csel_q <= wr_data;
        A_CFG:          cfg_q  <= wr_data;
        A_PULL:         pull_q <= wr_data;
        A_PORT, A_OLAT: olat_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_DIR:   rd_mux = dir_q;
      A_INV:   rd_mux = inv_q;
      A_IEN:   rd_mux = ien_q;
      A_DEFV:  rd_mux = defv_q;
      A_CSEL:  rd_mux = csel_q;
      A_CFG:   rd_mux = cfg_q;
      A_PULL:  rd_mux = pull_q;
      A_FLAG:  rd_mux = flag_q;
      A_CAP:   rd_mux = cap_q;
      A_PORT:  rd_mux = port_view;
      A_OLAT:  rd_mux = olat_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign pin_out = olat_q;
  assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpio_ioc_port_chk.sv
module gpio_ioc_port_chk
  import gpio_ioc_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [W-1:0]      wr_data,
  input logic              rd_en,
  input logic [W-1:0]      rd_data,
  input logic [W-1:0]      pin_out,
  input logic [W-1:0]      pin_oe,
  input logic              pend,
  input logic [W-1:0]      flag,
  input logic [W-1:0]      cap
);
  logic clr;
  assign clr = rd_en && ((addr == ADDR_W'(REG_CAP)) || (addr == ADDR_W'(REG_PORT)));

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R2
  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(REG_DIR)) |=> pin_oe == ~$past(wr_data)); // R3
  AST_OLAT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(REG_OLAT) || addr == ADDR_W'(REG_PORT)))
      |=> pin_out == $past(wr_data)); // R3
  AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pend |-> $countones(flag) == 1); // R7
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (pend && clr) |=> (!pend && flag == '0)); // R9
  AST_HOLD_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> (pend && $stable(flag) && $stable(cap))); // R10
  AST_HIGH_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr > ADDR_W'(REG_OLAT)) |=> rd_data == '0); // R12
endmodule

bind gpio_ioc_port gpio_ioc_port_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe),
  .pend(pend_q), .flag(flag_q), .cap(cap_q)
);

// File: tb/gpio_ioc_port_tb_top.sv
module gpio_ioc_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;
  logic       irq_out, irq_oe;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    started = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ioc_port dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_out(irq_out), .irq_oe(irq_oe)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_dir, m_inv, m_ien, m_defv, m_csel, m_cfg, m_pull, m_olat;
  logic [7:0] m_flag, m_cap, m_rd, m_s1, m_s2, m_prev;
  logic       m_pend;

  function automatic logic [7:0] m_read(input logic [7:0] a, input logic [7:0] pv);
    case (a)
      8'h00: return m_dir;
      8'h01: return m_inv;
      8'h02: return m_ien;
      8'h03: return m_defv;
      8'h04: return m_csel;
      8'h05: return m_cfg;
      8'h06: return m_pull;
      8'h07: return m_flag;
      8'h08: return m_cap;
      8'h09: return pv;
      8'h0A: return m_olat;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [7:0] pv, mm, lo;
    logic clr;
    pv  = m_s2 ^ (m_inv & m_dir);
    clr = rd_en && (addr == 8'h08 || addr == 8'h09);
    mm  = m_ien & ((m_csel & (m_s2 ^ m_defv)) | (~m_csel & (m_s2 ^ m_prev)));
    lo  = mm & (~mm + 8'd1);
    if (rst) begin
      m_dir = 8'hFF; m_inv = 0; m_ien = 0; m_defv = 0; m_csel = 0; m_cfg = 0;
      m_pull = 0; m_olat = 0; m_flag = 0; m_cap = 0; m_rd = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0;
    end else begin
      if (rd_en) m_rd = m_read(addr, pv);
      if (wr_en) begin
        case (addr)
          8'h00: m_dir = wr_data;
          8'h01: m_inv = wr_data;
          8'h02: m_ien = wr_data;
          8'h03: m_defv = wr_data;
          8'h04: m_csel = wr_data;
          8'h05: m_cfg = wr_data;
          8'h06: m_pull = wr_data;
          8'h09, 8'h0A: m_olat = wr_data;
          default: ;
        endcase
      end
      if (!m_pend || clr) m_prev = m_s2;
      if (m_pend && clr) begin
        m_pend = 1'b0; m_flag = 8'h00;
      end else if (!m_pend && mm != 8'h00) begin
        m_pend = 1'b1; m_flag = lo; m_cap = pv;
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
    started = 1'b1;
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (started) begin
      logic [1:0] mi;
      mi = m_cfg[2] ? {1'b0, m_pend} : {(m_cfg[1] ? m_pend : ~m_pend), 1'b1};
      chk(pin_oe, ~m_dir, "R3");
      chk(pin_out, m_olat, "R3");
      chk({6'b0, irq_out, irq_oe}, {6'b0, mi}, "R11");
      chk(rd_data, m_rd, cur_req);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    op(1'b1, 1'b0, a, d);
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [7:0] exp, input string req);
    cur_req = req;
    op(1'b0, 1'b1, a, 8'h00);
    chk(rd_data, exp, req);
  endtask

  task automatic setpin(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    idle(3);
    @(negedge clk) rst = 1'b0;
    chk(pin_oe, 8'h00, "R1");
    chk(pin_out, 8'h00, "R1");
    chk({6'b0, irq_out, irq_oe}, 8'h03, "R1");
    rd_exp(8'h00, 8'hFF, "R1");
    rd_exp(8'h07, 8'h00, "R1");
    rd_exp(8'h08, 8'h00, "R1");

    // R2 register readback
    wr(8'h01, 8'h5A); wr(8'h03, 8'h3C); wr(8'h04, 8'h0F); wr(8'h05, 8'h02);
    wr(8'h06, 8'hA5); wr(8'h0A, 8'h96); wr(8'h00, 8'hF0);
    rd_exp(8'h01, 8'h5A, "R2");
    rd_exp(8'h03, 8'h3C, "R2");
    rd_exp(8'h04, 8'h0F, "R2");
    rd_exp(8'h05, 8'h02, "R2");
    rd_exp(8'h06, 8'hA5, "R2");
    rd_exp(8'h0A, 8'h96, "R2");
    rd_exp(8'h00, 8'hF0, "R2");
    idle(2);
    chk(rd_data, 8'hF0, "R2");

    // R3 pad outputs, port-address write goes to latch
    chk(pin_oe, 8'h0F, "R3");
    chk(pin_out, 8'h96, "R3");
    wr(8'h09, 8'h33);
    chk(pin_out, 8'h33, "R3");
    rd_exp(8'h0A, 8'h33, "R3");

    // R4 port read, inversion on inputs only, sync latency
    wr(8'h04, 8'h00); wr(8'h00, 8'hFF); wr(8'h01, 8'h0F);
    setpin(8'hA5); idle(4);
    rd_exp(8'h09, 8'hAA, "R4");
    wr(8'h00, 8'hF0);
    rd_exp(8'h09, 8'hA5, "R4");
    setpin(8'h00);
    rd_exp(8'h09, 8'hA5, "R4");
    rd_exp(8'h09, 8'h00, "R4");

    // R5 compare-to-previous
    wr(8'h01, 8'h00); wr(8'h00, 8'hFF); wr(8'h05, 8'h00);
    wr(8'h02, 8'h10);
    idle(3);
    chk({7'b0, irq_out}, 8'h01, "R5");
    setpin(8'h10); idle(4);
    chk({7'b0, irq_out}, 8'h00, "R5");
    rd_exp(8'h07, 8'h10, "R5");
    chk({7'b0, irq_out}, 8'h00, "R9");
    rd_exp(8'h08, 8'h10, "R8");
    chk({7'b0, irq_out}, 8'h01, "R9");
    rd_exp(8'h07, 8'h00, "R9");

    // R13 disabled pin does nothing
    setpin(8'h11); idle(4);
    rd_exp(8'h07, 8'h00, "R13");
    chk({7'b0, irq_out}, 8'h01, "R13");

    // R7 lowest pin wins, R10 frozen while pending, R8 capture
    wr(8'h02, 8'hFF);
    setpin(8'h55); idle(4);
    rd_exp(8'h07, 8'h04, "R7");
    setpin(8'hFF); idle(4);
    rd_exp(8'h07, 8'h04, "R10");
    rd_exp(8'h08, 8'h55, "R10");
    rd_exp(8'h08, 8'h55, "R8");
    rd_exp(8'h07, 8'h00, "R9");

    // R9 only capture/port reads clear
    setpin(8'hFE); idle(4);
    rd_exp(8'h06, 8'hA5, "R9");
    chk({7'b0, irq_out}, 8'h00, "R9");
    rd_exp(8'h09, 8'hFE, "R9");
    chk({7'b0, irq_out}, 8'h01, "R9");

    // R6 compare-to-default with re-raise
    wr(8'h02, 8'h00); wr(8'h04, 8'h80); wr(8'h03, 8'h80); wr(8'h02, 8'h80);
    idle(2);
    rd_exp(8'h07, 8'h00, "R6");
    setpin(8'h7E); idle(4);
    rd_exp(8'h07, 8'h80, "R6");
    rd_exp(8'h09, 8'h7E, "R6");
    idle(2);
    rd_exp(8'h07, 8'h80, "R6");
    setpin(8'hFE); idle(4);
    rd_exp(8'h09, 8'hFE, "R6");
    idle(2);
    rd_exp(8'h07, 8'h00, "R6");

    // R11 interrupt pin modes
    wr(8'h05, 8'h02);
    chk({6'b0, irq_out, irq_oe}, 8'h01, "R11");
    setpin(8'h7E); idle(4);
    chk({6'b0, irq_out, irq_oe}, 8'h03, "R11");
    wr(8'h05, 8'h06);
    chk({6'b0, irq_out, irq_oe}, 8'h01, "R11");
    setpin(8'hFE); idle(4);
    rd_exp(8'h09, 8'hFE, "R11");
    chk({6'b0, irq_out, irq_oe}, 8'h00, "R11");
    wr(8'h05, 8'h00);

    // R12 unmapped and read-only addresses
    wr(8'h0C, 8'hFF);
    rd_exp(8'h0C, 8'h00, "R12");
    wr(8'h07, 8'hFF);
    rd_exp(8'h07, 8'h00, "R12");
    wr(8'h08, 8'h00);
    rd_exp(8'h08, 8'h7E, "R12");
    wr(8'h10, 8'h00);
    chk(pin_oe, 8'h00, "R12");
    rd_exp(8'hFF, 8'h00, "R12");

    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule